// File: doc/BRIEF.md
# Register Alias Table with Unit Tags

This block is the rename table of a small out-of-order core. It holds one entry per architectural register. An entry says one of two things. Either the register's current value is settled in the register file, or the value will come from an in-flight functional unit, and then the entry holds that unit's tag. There are four tags: 0 for the load/store unit and 1, 2 and 3 for the three adders. A decode group of up to four instructions is renamed every cycle. Each instruction's two source registers are resolved to a ready flag and a producer tag. Each instruction that writes a destination claims the entry with the tag of the unit it was assigned to. Because later writers replace the entry, write-after-read and write-after-write conflicts disappear. Read-after-write readiness is tracked in the same structure.

Result buses broadcast the tag of each finishing unit. The commit logic drives them in program order, so an entry is released only when its producer retires. An entry that still holds the broadcast tag goes back to "value in register file". A source that is looked up during the same cycle sees the broadcast at once. An entry that a newer producer has already claimed keeps that producer's tag when the older unit broadcasts. A flush input returns every entry to the register file. A two-flop synchronizer releases the asynchronous reset.

Top module: `rat_rename`

## Requirements
- R1: After reset release, every source of every lane reads ready (ready = 1).
- R2: When lane l has `dec_valid_i[l]` and `dec_dst_valid_i[l]` high, the entry named by its destination holds that lane's tag from the next cycle on. A later lookup of that register reads ready = 0 with that tag.
- R3: In a decode group, a source of lane l that equals the destination of a writing lane j < l reads ready = 0 in the same cycle. It takes the tag of the highest such j, whatever the table holds.
- R4: A lane's own destination and the destinations of higher lanes do not change its source lookups in that cycle. Those lookups see the table as it was before the group.
- R5: When several lanes of one group write the same register, the entry keeps the tag of the highest-numbered of those lanes.
- R6: A broadcast of tag T clears every entry that holds T and is not written in that cycle. From the next cycle on, lookups of those registers read ready = 1.
- R7: A source whose table entry holds tag T reads ready = 1 in the same cycle that T is broadcast, unless R3 applies to it.
- R8: A broadcast whose tag differs from the tag held in an entry leaves that entry busy with its tag unchanged. This holds when a newer producer has replaced the broadcasting unit.
- R9: A decode write to an entry in the same cycle as a broadcast of that entry's old tag leaves the entry busy with the new tag.
- R10: `flush_i` returns every entry to ready in the next cycle. It overrides decode writes in the same cycle.
- R11: A lane with `dec_valid_i` low or `dec_dst_valid_i` low neither changes the table nor forwards its destination to higher lanes.
- R12: Each of the `NUM_BUS` broadcast buses wakes entries on its own, and several buses may broadcast in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush_i | input | 1 | Return all entries to the register file |
| dec_valid_i | input | LANES | Lane holds an instruction |
| dec_dst_valid_i | input | LANES | Lane writes a destination register |
| dec_dst_i | input | LANES*AREG_W | Destination register per lane (lane l at bits l*AREG_W) |
| dec_tag_i | input | LANES*TAG_W | Producer unit tag per lane (0 load/store, 1..3 adders) |
| dec_src1_i | input | LANES*AREG_W | First source register per lane |
| dec_src2_i | input | LANES*AREG_W | Second source register per lane |
| bc_valid_i | input | NUM_BUS | Broadcast bus carries a result |
| bc_tag_i | input | NUM_BUS*TAG_W | Tag on each broadcast bus |
| src1_rdy_o | output | LANES | First source of each lane is ready |
| src1_tag_o | output | LANES*TAG_W | Producer tag of first source (meaningful when not ready) |
| src2_rdy_o | output | LANES | Second source of each lane is ready |
| src2_tag_o | output | LANES*TAG_W | Producer tag of second source (meaningful when not ready) |

## Verification
Wakeup by broadcast and claiming by decode can hit the same entry in one cycle. So can the same-cycle broadcast bypass and the in-group forwarding on the same source. The bench provokes both collisions on purpose. It writes a register while the unit that owns its entry broadcasts. It also reads a broadcast register from a lane that sits behind a writer of that register in the same group. A reference table kept in the bench judges each collision. The new writer must win the entry (R9). The in-group producer must win the source over the bypass (R3, R7).

// File: rtl/rat_pkg.sv
package rat_pkg;
  localparam int DEF_LANES     = 4;
  localparam int DEF_AREG_W    = 3;
  localparam int DEF_NUM_UNITS = 4;
  localparam int DEF_NUM_BUS   = 2;

  typedef enum logic [1:0] {
    UNIT_LDST = 2'd0,
    UNIT_ADD1 = 2'd1,
    UNIT_ADD2 = 2'd2,
    UNIT_ADD3 = 2'd3
  } unit_e;
endpackage

// File: rtl/rat_rst_sync.sv
module rat_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/rat_entry.sv
module rat_entry #(
  parameter int LANES   = 4,
  parameter int TAG_W   = 2,
  parameter int NUM_BUS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush_i,
  input  logic [LANES-1:0]         wr_i,
  input  logic [LANES*TAG_W-1:0]   wr_tag_i,
  input  logic [NUM_BUS-1:0]       bc_valid_i,
  input  logic [NUM_BUS*TAG_W-1:0] bc_tag_i,
  output logic                     busy_o,
  output logic [TAG_W-1:0]         tag_o
);
  logic             busy_q, busy_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             load_en;
  logic             wake;
  logic [TAG_W-1:0] wr_tag;

  always_comb begin
    wake   = 1'b0;
    wr_tag = tag_q;
    for (int b = 0; b < NUM_BUS; b++)
      if (bc_valid_i[b] && bc_tag_i[b*TAG_W +: TAG_W] == tag_q) wake = busy_q;
    // highest lane wins the entry
    for (int l = 0; l < LANES; l++)
      if (wr_i[l]) wr_tag = wr_tag_i[l*TAG_W +: TAG_W];

    busy_d  = busy_q;
    tag_d   = tag_q;
    load_en = 1'b0;
    if (flush_i) begin
      busy_d  = 1'b0;
      load_en = busy_q;
    end else if (|wr_i) begin
      busy_d  = 1'b1;
      tag_d   = wr_tag;
      load_en = 1'b1;
    end else if (wake) begin
      busy_d  = 1'b0;
      load_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tag_q  <= '0;
    end else if (load_en) begin
      busy_q <= busy_d;
      tag_q  <= tag_d;
    end
  end

  assign busy_o = busy_q;
  assign tag_o  = tag_q;
endmodule

// File: rtl/rat_srcsel.sv
module rat_srcsel #(
  parameter int LANES   = 4,
  parameter int AREG_W  = 3,
  parameter int TAG_W   = 2,
  parameter int NUM_BUS = 2,
  localparam int NUM_AREGS = 1 << AREG_W,
  localparam int FW        = LANES - 1
) (
  input  logic [LANES*AREG_W-1:0]  src1_i,
  input  logic [LANES*AREG_W-1:0]  src2_i,
  input  logic [NUM_AREGS-1:0]     tab_busy_i,
  input  logic [NUM_AREGS*TAG_W-1:0] tab_tag_i,
  input  logic [FW-1:0]            fw_wr_i,
  input  logic [FW*AREG_W-1:0]     fw_dst_i,
  input  logic [FW*TAG_W-1:0]      fw_tag_i,
  input  logic [NUM_BUS-1:0]       bc_valid_i,
  input  logic [NUM_BUS*TAG_W-1:0] bc_tag_i,
  output logic [LANES-1:0]         rdy1_o,
  output logic [LANES*TAG_W-1:0]   tag1_o,
  output logic [LANES-1:0]         rdy2_o,
  output logic [LANES*TAG_W-1:0]   tag2_o
);
  function automatic logic [TAG_W:0] resolve(input logic [AREG_W-1:0] s, input int lane);
    logic             r;
    logic             hit;
    logic [TAG_W-1:0] t;
    t   = tab_tag_i[int'(s)*TAG_W +: TAG_W];
    hit = 1'b0;
    for (int b = 0; b < NUM_BUS; b++)
      if (bc_valid_i[b] && bc_tag_i[b*TAG_W +: TAG_W] == t) hit = 1'b1;
    r = !tab_busy_i[s] || hit;
    // older producer in the same group overrides the table
    for (int j = 0; j < FW; j++)
      if (j < lane && fw_wr_i[j] && fw_dst_i[j*AREG_W +: AREG_W] == s) begin
        r = 1'b0;
        t = fw_tag_i[j*TAG_W +: TAG_W];
      end
    return {r, t};
  endfunction

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      {rdy1_o[l], tag1_o[l*TAG_W +: TAG_W]} = resolve(src1_i[l*AREG_W +: AREG_W], l);
      {rdy2_o[l], tag2_o[l*TAG_W +: TAG_W]} = resolve(src2_i[l*AREG_W +: AREG_W], l);
    end
  end
endmodule

// File: rtl/rat_rename.sv
module rat_rename #(
  parameter int LANES     = rat_pkg::DEF_LANES,
  parameter int AREG_W    = rat_pkg::DEF_AREG_W,
  parameter int NUM_UNITS = rat_pkg::DEF_NUM_UNITS,
  parameter int NUM_BUS   = rat_pkg::DEF_NUM_BUS,
  localparam int TAG_W     = $clog2(NUM_UNITS),
  localparam int NUM_AREGS = 1 << AREG_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush_i,
  input  logic [LANES-1:0]         dec_valid_i,
  input  logic [LANES-1:0]         dec_dst_valid_i,
  input  logic [LANES*AREG_W-1:0]  dec_dst_i,
  input  logic [LANES*TAG_W-1:0]   dec_tag_i,
  input  logic [LANES*AREG_W-1:0]  dec_src1_i,
  input  logic [LANES*AREG_W-1:0]  dec_src2_i,
  input  logic [NUM_BUS-1:0]       bc_valid_i,
  input  logic [NUM_BUS*TAG_W-1:0] bc_tag_i,
  output logic [LANES-1:0]         src1_rdy_o,
  output logic [LANES*TAG_W-1:0]   src1_tag_o,
  output logic [LANES-1:0]         src2_rdy_o,
  output logic [LANES*TAG_W-1:0]   src2_tag_o
);
  logic                       rst_sync_n;
  logic [LANES-1:0]           lane_wr;
  logic [NUM_AREGS-1:0]       tab_busy;
  logic [NUM_AREGS*TAG_W-1:0] tab_tag;
  logic [LANES-1:0]           ent_wr [NUM_AREGS];

  rat_rst_sync u_rst (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_sync_n));

  assign lane_wr = dec_valid_i & dec_dst_valid_i;

  for (genvar r = 0; r < NUM_AREGS; r++) begin : g_ent
    for (genvar l = 0; l < LANES; l++) begin : g_dec
      assign ent_wr[r][l] = lane_wr[l] && (dec_dst_i[l*AREG_W +: AREG_W] == AREG_W'(r));
    end
    rat_entry #(.LANES(LANES), .TAG_W(TAG_W), .NUM_BUS(NUM_BUS)) u_entry (
      .clk(clk), .rst_n(rst_sync_n), .flush_i(flush_i),
      .wr_i(ent_wr[r]), .wr_tag_i(dec_tag_i),
      .bc_valid_i(bc_valid_i), .bc_tag_i(bc_tag_i),
      .busy_o(tab_busy[r]), .tag_o(tab_tag[r*TAG_W +: TAG_W])
    );
  end

  rat_srcsel #(.LANES(LANES), .AREG_W(AREG_W), .TAG_W(TAG_W), .NUM_BUS(NUM_BUS)) u_srcsel (
    .src1_i(dec_src1_i), .src2_i(dec_src2_i),
    .tab_busy_i(tab_busy), .tab_tag_i(tab_tag),
    .fw_wr_i(lane_wr[LANES-2:0]),
    .fw_dst_i(dec_dst_i[(LANES-1)*AREG_W-1:0]),
    .fw_tag_i(dec_tag_i[(LANES-1)*TAG_W-1:0]),
    .bc_valid_i(bc_valid_i), .bc_tag_i(bc_tag_i),
    .rdy1_o(src1_rdy_o), .tag1_o(src1_tag_o),
    .rdy2_o(src2_rdy_o), .tag2_o(src2_tag_o)
  );
endmodule

// File: rtl/rat_rename_chk.sv
module rat_rename_chk #(
  parameter int LANES   = 4,
  parameter int AREG_W  = 3,
  parameter int TAG_W   = 2,
  parameter int NUM_BUS = 2,
  localparam int NUM_AREGS = 1 << AREG_W
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       flush_i,
  input logic [LANES-1:0]           lane_wr,
  input logic [LANES*AREG_W-1:0]    dec_dst_i,
  input logic [LANES*TAG_W-1:0]     dec_tag_i,
  input logic [LANES*AREG_W-1:0]    dec_src1_i,
  input logic [NUM_BUS-1:0]         bc_valid_i,
  input logic [NUM_BUS*TAG_W-1:0]   bc_tag_i,
  input logic [NUM_AREGS-1:0]       tab_busy,
  input logic [NUM_AREGS*TAG_W-1:0] tab_tag,
  input logic [LANES-1:0]           src1_rdy_o,
  input logic [LANES*TAG_W-1:0]     src1_tag_o,
  input logic [LANES-1:0]           src2_rdy_o
);
  logic [AREG_W-1:0]    last_dst;
  logic [TAG_W-1:0]     last_tag;
  logic [AREG_W-1:0]    src0;
  logic [NUM_AREGS-1:0] chk_wr;
  logic [NUM_AREGS-1:0] chk_bm;

  assign last_dst = dec_dst_i[(LANES-1)*AREG_W +: AREG_W];
  assign last_tag = dec_tag_i[(LANES-1)*TAG_W +: TAG_W];
  assign src0     = dec_src1_i[AREG_W-1:0];

  always_comb begin
    chk_wr = '0;
    chk_bm = '0;
    for (int r = 0; r < NUM_AREGS; r++) begin
      for (int l = 0; l < LANES; l++)
        if (lane_wr[l] && int'(dec_dst_i[l*AREG_W +: AREG_W]) == r) chk_wr[r] = 1'b1;
      for (int b = 0; b < NUM_BUS; b++)
        if (bc_valid_i[b] && bc_tag_i[b*TAG_W +: TAG_W] == tab_tag[r*TAG_W +: TAG_W]) chk_bm[r] = 1'b1;
    end
  end

  assert_last_lane_claims_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_i && lane_wr[LANES-1] |=> tab_busy[$past(last_dst)] &&
      (tab_tag[int'($past(last_dst))*TAG_W +: TAG_W] == $past(last_tag)));

  assert_group_forward_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lane_wr[0] && dec_src1_i[2*AREG_W-1:AREG_W] == dec_dst_i[AREG_W-1:0] && !lane_wr[LANES-1]
      |-> !src1_rdy_o[1] && src1_tag_o[2*TAG_W-1:TAG_W] == dec_tag_i[TAG_W-1:0]);

  assert_lane0_table_view_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tab_busy[src0] |-> src1_rdy_o[0]);

  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> tab_busy == '0 && src1_rdy_o[0] && src2_rdy_o[0]);

  for (genvar r = 0; r < NUM_AREGS; r++) begin : g_ent
    assert_wake_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tab_busy[r] && chk_bm[r] && !chk_wr[r] && !flush_i |=> !tab_busy[r]);
    assert_stale_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tab_busy[r] && !chk_bm[r] && !chk_wr[r] && !flush_i |=>
        tab_busy[r] && $stable(tab_tag[r*TAG_W +: TAG_W]));
  end
endmodule

bind rat_rename rat_rename_chk #(.LANES(LANES), .AREG_W(AREG_W), .TAG_W(TAG_W), .NUM_BUS(NUM_BUS)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .flush_i(flush_i), .lane_wr(lane_wr),
  .dec_dst_i(dec_dst_i), .dec_tag_i(dec_tag_i), .dec_src1_i(dec_src1_i),
  .bc_valid_i(bc_valid_i), .bc_tag_i(bc_tag_i),
  .tab_busy(tab_busy), .tab_tag(tab_tag),
  .src1_rdy_o(src1_rdy_o), .src1_tag_o(src1_tag_o), .src2_rdy_o(src2_rdy_o)
);

// File: tb/rat_rename_bench.sv
module rat_rename_bench;
  localparam int LANES = 4, AREG_W = 3, NUM_BUS = 2, TAG_W = 2, NREG = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, flush_i;
  logic [LANES-1:0] dec_valid_i, dec_dst_valid_i, src1_rdy_o, src2_rdy_o;
  logic [LANES*AREG_W-1:0] dec_dst_i, dec_src1_i, dec_src2_i;
  logic [LANES*TAG_W-1:0] dec_tag_i, src1_tag_o, src2_tag_o;
  logic [NUM_BUS-1:0] bc_valid_i;
  logic [NUM_BUS*TAG_W-1:0] bc_tag_i;

  rat_rename u_rat_rename (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // staged stimulus
  logic             sv [LANES], sdv [LANES];
  logic [2:0]       sd [LANES], ss1 [LANES], ss2 [LANES];
  logic [1:0]       stg [LANES];
  logic             sbv [NUM_BUS];
  logic [1:0]       sbt [NUM_BUS];
  logic             sfl;
  // reference table
  logic             mb [NREG];
  logic [1:0]       mt [NREG];

  task automatic clr();
    for (int l = 0; l < LANES; l++) begin
      sv[l] = 0; sdv[l] = 0; sd[l] = 0; ss1[l] = 0; ss2[l] = 0; stg[l] = 0;
    end
    for (int b = 0; b < NUM_BUS; b++) begin sbv[b] = 0; sbt[b] = 0; end
    sfl = 0;
  endtask

  function automatic logic [2:0] expect_src(input logic [2:0] s, input int lane);
    logic r, hit; logic [1:0] t;
    t = mt[s]; hit = 0;
    for (int b = 0; b < NUM_BUS; b++) if (sbv[b] && sbt[b] == t) hit = 1;
    r = !mb[s] || hit;
    for (int j = 0; j < lane; j++)
      if (sv[j] && sdv[j] && sd[j] == s) begin r = 0; t = stg[j]; end
    return {r, t};
  endfunction

  task automatic one(string req, int lane, int sn, logic ar, logic [1:0] at, logic [2:0] e);
    n_chk++;
    if (ar !== e[2] || (!e[2] && at !== e[1:0])) begin
      n_fail++;
      $display("FAIL %s lane%0d src%0d: rdy=%0b tag=%0d expected rdy=%0b tag=%0d",
               req, lane, sn, ar, at, e[2], e[1:0]);
    end
  endtask

  task automatic cyc(string req);
    logic busy_n [NREG]; logic [1:0] tag_n [NREG]; logic any, hit;
    @(negedge clk);
    flush_i = sfl;
    for (int l = 0; l < LANES; l++) begin
      dec_valid_i[l] = sv[l]; dec_dst_valid_i[l] = sdv[l];
      dec_dst_i[l*AREG_W +: AREG_W] = sd[l]; dec_tag_i[l*TAG_W +: TAG_W] = stg[l];
      dec_src1_i[l*AREG_W +: AREG_W] = ss1[l]; dec_src2_i[l*AREG_W +: AREG_W] = ss2[l];
    end
    for (int b = 0; b < NUM_BUS; b++) begin
      bc_valid_i[b] = sbv[b]; bc_tag_i[b*TAG_W +: TAG_W] = sbt[b];
    end
    #2;
    for (int l = 0; l < LANES; l++) begin
      one(req, l, 1, src1_rdy_o[l], src1_tag_o[l*TAG_W +: TAG_W], expect_src(ss1[l], l));
      one(req, l, 2, src2_rdy_o[l], src2_tag_o[l*TAG_W +: TAG_W], expect_src(ss2[l], l));
    end
    for (int r = 0; r < NREG; r++) begin
      busy_n[r] = mb[r]; tag_n[r] = mt[r]; any = 0; hit = 0;
      for (int l = 0; l < LANES; l++)
        if (sv[l] && sdv[l] && sd[l] == 3'(r)) begin any = 1; tag_n[r] = stg[l]; end
      for (int b = 0; b < NUM_BUS; b++) if (sbv[b] && sbt[b] == mt[r]) hit = 1;
      if (sfl) busy_n[r] = 0;
      else if (any) busy_n[r] = 1;
      else if (hit) busy_n[r] = 0;
    end
    for (int r = 0; r < NREG; r++) begin mb[r] = busy_n[r]; mt[r] = tag_n[r]; end
  endtask

  task automatic wr(int lane, int d, int t);
    sv[lane] = 1; sdv[lane] = 1; sd[lane] = 3'(d); stg[lane] = 2'(t);
  endtask

  // read all registers across lanes, no writes
  task automatic sweep_read(string req);
    clr();
    for (int l = 0; l < LANES; l++) begin ss1[l] = 3'(l); ss2[l] = 3'(l + 4); end
    cyc(req);
  endtask

  logic [31:0] lfsr = 32'h1ACE_5EED;
  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; flush_i = 0; dec_valid_i = 0; dec_dst_valid_i = 0; dec_dst_i = 0;
    dec_tag_i = 0; dec_src1_i = 0; dec_src2_i = 0; bc_valid_i = 0; bc_tag_i = 0;
    for (int r = 0; r < NREG; r++) begin mb[r] = 0; mt[r] = 0; end
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    sweep_read("R1");

    // R2: claim every register, tag = r mod 4, one lane per cycle
    for (int r = 0; r < NREG; r++) begin
      clr(); wr(r % LANES, r, r % 4); cyc("R2");
    end
    sweep_read("R2");
    clr(); sfl = 1; cyc("R10"); sweep_read("R10");

    // R4: lane writes a register it also reads; higher lane writes too
    for (int l = 0; l < LANES; l++) begin
      clr(); wr(l, 2, l); ss1[l] = 2; ss2[l] = 2;
      if (l > 0) begin ss1[l-1] = 2; end
      cyc("R4");
    end
    clr(); sfl = 1; cyc("R10");

    // R3: forwarding picks the nearest older writer
    clr(); wr(0, 3, 1); ss1[1] = 3; wr(2, 3, 2); ss1[3] = 3; ss2[3] = 3; ss2[2] = 3;
    cyc("R3");

    // R5: all lanes write register 5
    clr(); for (int l = 0; l < LANES; l++) wr(l, 5, l); cyc("R5");
    sweep_read("R5");

    // R7 and R3 together: broadcast tag 3 while reg5 read; lane1 behind lane0 writer of reg5
    clr(); sbv[0] = 1; sbt[0] = 3; ss1[0] = 5; wr(0, 5, 1); ss1[1] = 5; ss2[2] = 3;
    cyc("R7");
    sweep_read("R6");
    clr(); sbv[1] = 1; sbt[1] = 1; ss1[0] = 5; cyc("R7");
    sweep_read("R6");

    // R12: two entries with tag 2, two with tag 0, both buses fire
    clr(); wr(0, 1, 2); wr(1, 6, 2); wr(2, 0, 0); wr(3, 7, 0); cyc("R12");
    clr(); sbv[1] = 1; sbt[1] = 2; ss1[0] = 1; ss2[0] = 6; cyc("R12");
    sweep_read("R12");
    clr(); sbv[0] = 1; sbt[0] = 0; sbv[1] = 1; sbt[1] = 3; cyc("R12");
    sweep_read("R12");

    // R8: reg4 claimed by tag1 then tag2; tag1 broadcast must not free it
    clr(); wr(0, 4, 1); cyc("R8");
    clr(); wr(3, 4, 2); cyc("R8");
    clr(); sbv[0] = 1; sbt[0] = 1; ss1[0] = 4; cyc("R8");
    sweep_read("R8");

    // R9: write and wake the same entry in one cycle
    clr(); sbv[1] = 1; sbt[1] = 2; wr(1, 4, 3); ss1[0] = 4; cyc("R9");
    sweep_read("R9");

    // R11: invalid lanes and non-writing lanes
    clr(); sv[0] = 0; sdv[0] = 1; sd[0] = 0; sv[1] = 1; sdv[1] = 0; sd[1] = 1;
    ss1[1] = 0; ss1[2] = 1; ss2[3] = 0; cyc("R11");
    sweep_read("R11");

    // R10: flush overrides same-cycle writes
    clr(); sfl = 1; for (int l = 0; l < LANES; l++) wr(l, l, l); cyc("R10");
    sweep_read("R10");

    // mixed traffic sweep against the reference table
    for (int i = 0; i < 600; i++) begin
      clr();
      for (int l = 0; l < LANES; l++) begin
        lfsr = nxt(lfsr);
        sv[l] = lfsr[0]; sdv[l] = lfsr[1]; sd[l] = lfsr[4:2]; stg[l] = lfsr[6:5];
        ss1[l] = lfsr[9:7]; ss2[l] = lfsr[12:10];
      end
      lfsr = nxt(lfsr);
      sbv[0] = lfsr[0]; sbt[0] = lfsr[2:1]; sbv[1] = lfsr[3]; sbt[1] = lfsr[5:4];
      sfl = (lfsr[11:6] == 6'd0);
      cyc("R2");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule